// File: doc/BRIEF.md
# Integer Arithmetic and Logic Unit

This unit does the integer execute step of a 32-bit load/store processor core. The core decodes the instruction and reads the register file. It then gives this unit two register operands, the raw 16-bit immediate field, a 5-bit shift count and a 5-bit operation code. In the same cycle the unit returns a 32-bit result and a write-enable for the destination register.

Immediates enter unextended. The unit widens them itself: the arithmetic and compare forms sign-extend, and the bitwise forms zero-extend. Only the trapping add and subtract forms can signal overflow. When they do, the result is still driven, the write-enable drops in the same cycle, and a registered overflow strobe rises on the next clock edge for the exception logic outside the unit.

Top module: `int_alu`

## Requirements
- R1: Codes 0 (trapping add), 1 (wrapping add), 2 (trapping subtract) and 3 (wrapping subtract) return a_i+b_i or a_i-b_i modulo 2^32 in the same cycle. When there is no overflow, wr_en_o is 1.
- R2: A signed overflow on code 0, 2 or 10 (trapping add-immediate) still drives the sum or difference on result_o and pulls wr_en_o to 0 in the same cycle. It sets ovf_o to 1 for exactly the clock cycle that follows each overflowing operation.
- R3: Codes 1, 3 and 11 (wrapping add-immediate) never raise ovf_o and always keep wr_en_o at 1, even when the signed result wraps.
- R4: Codes 10, 11, 15 (signed compare-immediate) and 16 (unsigned compare-immediate) copy imm_i bit 15 into bits 31:16 of the second operand.
- R5: Codes 4, 5, 6 and 7 return a_i AND b_i, a_i OR b_i, a_i XOR b_i and NOT(a_i OR b_i), in that order.
- R6: Codes 12, 13 and 14 apply AND, OR and XOR between a_i and imm_i zero-extended to 32 bits.
- R7: Codes 8 (register) and 15 (immediate) return 1 when a_i is less than the second operand as two's-complement values, and 0 otherwise. Bits 31:1 are always 0, and ovf_o is never raised.
- R8: Codes 9 (register) and 16 (immediate) return 1 when a_i is less than the second operand as unsigned values, and 0 otherwise.
- R9: Codes 18 (left), 19 (right logical) and 20 (right arithmetic) shift b_i by shamt_i. The arithmetic right shift fills vacated bits with b_i bit 31, and the other two fill with 0.
- R10: Codes 21, 22 and 23 shift b_i left, right logical and right arithmetic by a_i[4:0]. a_i[31:5] and shamt_i have no effect on these codes.
- R11: Code 17 returns {imm_i, 16'h0000}, whatever a_i and b_i hold.
- R12: Codes 24 to 31 are undefined. They return result_o = 0 and wr_en_o = 0, and they never raise ovf_o.
- R13: While rst is high at a clock edge, ovf_o is 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the overflow strobe register |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 5 | Operation code (see requirements) |
| a_i | input | 32 | First register operand, also the variable shift count |
| b_i | input | 32 | Second register operand, also the value that is shifted |
| imm_i | input | 16 | Raw immediate field |
| shamt_i | input | 5 | Constant shift count |
| result_o | output | 32 | Combinational result |
| wr_en_o | output | 1 | Destination write-enable, low on trap or undefined code |
| ovf_o | output | 1 | Overflow strobe, one cycle after the trapping operation |

## Verification
Almost all of the unit is combinational, so a wrong extension rule, mux select or shift stage shows up on result_o in the same cycle the operation is applied. The test vectors are chosen so that sign and zero extension give different results, signed and unsigned compares disagree, and each shift stage changes the output. A wrong overflow condition or trap selection shows up in two places: first on wr_en_o in the same cycle, then on ovf_o one edge later. Back-to-back overflowing operations check that the strobe lasts one cycle per event and does not stick.

// File: rtl/alu_pkg.sv
package alu_pkg;
    localparam int DATA_W = 32;
    localparam int IMM_W  = 16;
    localparam int SH_W   = $clog2(DATA_W);
    localparam int OP_W   = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ADD_TRAP  = 5'd0,  OP_ADD_WRAP  = 5'd1,
        OP_SUB_TRAP  = 5'd2,  OP_SUB_WRAP  = 5'd3,
        OP_AND       = 5'd4,  OP_OR        = 5'd5,
        OP_XOR       = 5'd6,  OP_NOR       = 5'd7,
        OP_LT_S      = 5'd8,  OP_LT_U      = 5'd9,
        OP_ADDI_TRAP = 5'd10, OP_ADDI_WRAP = 5'd11,
        OP_ANDI      = 5'd12, OP_ORI       = 5'd13,
        OP_XORI      = 5'd14, OP_LTI_S     = 5'd15,
        OP_LTI_U     = 5'd16, OP_UPPER     = 5'd17,
        OP_SHL       = 5'd18, OP_SHR       = 5'd19,
        OP_SHRA      = 5'd20, OP_SHLV      = 5'd21,
        OP_SHRV      = 5'd22, OP_SHRAV     = 5'd23
    } op_e;

    typedef enum logic [2:0] {
        U_NONE, U_ARITH, U_LOGIC, U_CMP, U_SHIFT, U_UPPER
    } unit_e;

    typedef enum logic [1:0] {LF_AND, LF_OR, LF_XOR, LF_NOR} logic_fn_e;

    typedef struct packed {
        unit_e     unit;
        logic      use_imm;
        logic      imm_sext;
        logic      sub;
        logic      trap;
        logic      cmp_uns;
        logic_fn_e lfn;
        logic      sh_left;
        logic      sh_arith;
        logic      sh_var;
    } ctrl_t;

    function automatic ctrl_t decode_op(logic [OP_W-1:0] code);
        ctrl_t c;
        c = '0;
        c.unit = U_NONE;
        c.lfn  = LF_AND;
        case (code)
            OP_ADD_TRAP:  begin c.unit = U_ARITH; c.trap = 1'b1; end
            OP_ADD_WRAP:  c.unit = U_ARITH;
            OP_SUB_TRAP:  begin c.unit = U_ARITH; c.sub = 1'b1; c.trap = 1'b1; end
            OP_SUB_WRAP:  begin c.unit = U_ARITH; c.sub = 1'b1; end
            OP_AND:       begin c.unit = U_LOGIC; c.lfn = LF_AND; end
            OP_OR:        begin c.unit = U_LOGIC; c.lfn = LF_OR;  end
            OP_XOR:       begin c.unit = U_LOGIC; c.lfn = LF_XOR; end
            OP_NOR:       begin c.unit = U_LOGIC; c.lfn = LF_NOR; end
            OP_LT_S:      begin c.unit = U_CMP; c.sub = 1'b1; end
            OP_LT_U:      begin c.unit = U_CMP; c.sub = 1'b1; c.cmp_uns = 1'b1; end
            OP_ADDI_TRAP: begin c.unit = U_ARITH; c.use_imm = 1'b1; c.imm_sext = 1'b1; c.trap = 1'b1; end
            OP_ADDI_WRAP: begin c.unit = U_ARITH; c.use_imm = 1'b1; c.imm_sext = 1'b1; end
            OP_ANDI:      begin c.unit = U_LOGIC; c.use_imm = 1'b1; c.lfn = LF_AND; end
            OP_ORI:       begin c.unit = U_LOGIC; c.use_imm = 1'b1; c.lfn = LF_OR;  end
            OP_XORI:      begin c.unit = U_LOGIC; c.use_imm = 1'b1; c.lfn = LF_XOR; end
            OP_LTI_S:     begin c.unit = U_CMP; c.use_imm = 1'b1; c.imm_sext = 1'b1; c.sub = 1'b1; end
            OP_LTI_U:     begin c.unit = U_CMP; c.use_imm = 1'b1; c.imm_sext = 1'b1; c.sub = 1'b1; c.cmp_uns = 1'b1; end
            OP_UPPER:     c.unit = U_UPPER;
            OP_SHL:       begin c.unit = U_SHIFT; c.sh_left = 1'b1; end
            OP_SHR:       c.unit = U_SHIFT;
            OP_SHRA:      begin c.unit = U_SHIFT; c.sh_arith = 1'b1; end
            OP_SHLV:      begin c.unit = U_SHIFT; c.sh_left = 1'b1; c.sh_var = 1'b1; end
            OP_SHRV:      begin c.unit = U_SHIFT; c.sh_var = 1'b1; end
            OP_SHRAV:     begin c.unit = U_SHIFT; c.sh_arith = 1'b1; c.sh_var = 1'b1; end
            default:      c.unit = U_NONE;
        endcase
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] widen_imm(logic [IMM_W-1:0] imm, logic sext);
        return {{(DATA_W-IMM_W){sext & imm[IMM_W-1]}}, imm};
    endfunction
endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         carry,
    output logic         ovf
);
    logic [W-1:0] opb_x;
    logic [W:0]   full;

    always_comb begin
        opb_x = sub ? ~opb : opb;
        full  = {1'b0, opa} + {1'b0, opb_x} + {{W{1'b0}}, sub};
        sum   = full[W-1:0];
        carry = full[W];
        ovf   = (opa[W-1] == opb_x[W-1]) && (full[W-1] != opa[W-1]);
    end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
    parameter int W  = 32,
    parameter int SW = $clog2(W)
) (
    input  logic [W-1:0]  val,
    input  logic [SW-1:0] amt,
    input  logic          left,
    input  logic          arith,
    output logic [W-1:0]  out
);
    logic         fill;
    logic [W-1:0] pre;
    logic [W-1:0] stg [SW+1];

    always_comb begin
        fill = arith & ~left & val[W-1];
        for (int i = 0; i < W; i++) begin
            pre[i] = left ? val[W-1-i] : val[i];
        end
    end

    assign stg[0] = pre;

    for (genvar k = 0; k < SW; k++) begin : g_stage
        localparam int STEP = 1 << k;
        assign stg[k+1] = amt[k] ? {{STEP{fill}}, stg[k][W-1:STEP]} : stg[k];
    end

    always_comb begin
        for (int i = 0; i < W; i++) begin
            out[i] = left ? stg[SW][W-1-i] : stg[SW][i];
        end
    end
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
    parameter int W = 32
) (
    input  logic [W-1:0]       opa,
    input  logic [W-1:0]       opb,
    input  alu_pkg::logic_fn_e fn,
    output logic [W-1:0]       out
);
    import alu_pkg::*;
    always_comb begin
        case (fn)
            LF_AND:  out = opa & opb;
            LF_OR:   out = opa | opb;
            LF_XOR:  out = opa ^ opb;
            default: out = ~(opa | opb);
        endcase
    end
endmodule

// File: rtl/int_alu.sv
module int_alu
    import alu_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [OP_W-1:0]     op_i,
    input  logic [DATA_W-1:0]   a_i,
    input  logic [DATA_W-1:0]   b_i,
    input  logic [IMM_W-1:0]    imm_i,
    input  logic [SH_W-1:0]     shamt_i,
    output logic [DATA_W-1:0]   result_o,
    output logic                wr_en_o,
    output logic                ovf_o
);
    ctrl_t             ctrl;
    logic [DATA_W-1:0] opb;
    logic [SH_W-1:0]   amt;
    logic [DATA_W-1:0] sum, lres, sres;
    logic              carry, ovf_raw, lt, ovf_now;

    always_comb begin
        ctrl = decode_op(op_i);
        opb  = ctrl.use_imm ? widen_imm(imm_i, ctrl.imm_sext) : b_i;
        amt  = ctrl.sh_var ? a_i[SH_W-1:0] : shamt_i;
    end

    alu_adder #(.W(DATA_W)) u_add (
        .opa(a_i), .opb(opb), .sub(ctrl.sub),
        .sum(sum), .carry(carry), .ovf(ovf_raw)
    );

    alu_logic #(.W(DATA_W)) u_logic (
        .opa(a_i), .opb(opb), .fn(ctrl.lfn), .out(lres)
    );

    alu_shifter #(.W(DATA_W), .SW(SH_W)) u_shift (
        .val(b_i), .amt(amt), .left(ctrl.sh_left),
        .arith(ctrl.sh_arith), .out(sres)
    );

    always_comb begin
        lt      = ctrl.cmp_uns ? ~carry : (sum[DATA_W-1] ^ ovf_raw);
        ovf_now = ctrl.trap & ovf_raw;
        wr_en_o = (ctrl.unit != U_NONE) & ~ovf_now;
        case (ctrl.unit)
            U_ARITH: result_o = sum;
            U_LOGIC: result_o = lres;
            U_CMP:   result_o = {{(DATA_W-1){1'b0}}, lt};
            U_SHIFT: result_o = sres;
            U_UPPER: result_o = {imm_i, {(DATA_W-IMM_W){1'b0}}};
            default: result_o = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ovf_o <= 1'b0;
        else     ovf_o <= ovf_now;
    end

    AST_TRAP_ONLY: assert property (@(posedge clk) disable iff (rst)
        ovf_o |-> ($past(op_i) inside {OP_ADD_TRAP, OP_SUB_TRAP, OP_ADDI_TRAP})); // R2
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (op_i inside {OP_ADD_WRAP, OP_SUB_WRAP, OP_ADDI_WRAP}) |-> wr_en_o); // R3
    AST_CMP_BOOL: assert property (@(posedge clk) disable iff (rst)
        (op_i inside {OP_LT_S, OP_LT_U, OP_LTI_S, OP_LTI_U}) |-> (result_o[DATA_W-1:1] == '0)); // R7
    AST_UPPER_FORM: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_UPPER) |-> (result_o == {imm_i, {(DATA_W-IMM_W){1'b0}}})); // R11
    AST_UNDEF_QUIET: assert property (@(posedge clk) disable iff (rst)
        (op_i > OP_SHRAV) |-> (!wr_en_o && result_o == '0)); // R12
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> !ovf_o); // R13
endmodule

// File: tb/int_alu_bench.sv
module int_alu_bench;
    import alu_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [4:0]        op_i = '0;
    logic [31:0]       a_i = '0, b_i = '0;
    logic [15:0]       imm_i = '0;
    logic [4:0]        shamt_i = '0;
    logic [31:0]       result_o;
    logic              wr_en_o, ovf_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    int_alu u_int_alu (
        .clk(clk), .rst(rst), .op_i(op_i), .a_i(a_i), .b_i(b_i),
        .imm_i(imm_i), .shamt_i(shamt_i),
        .result_o(result_o), .wr_en_o(wr_en_o), .ovf_o(ovf_o)
    );

    typedef struct packed {
        logic [4:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic [15:0] imm;
        logic [4:0]  sh;
        logic [31:0] res;
        logic        wen;
        logic        ovf;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 36;
    localparam vec_t VECS [NV] = '{
        '{5'd0,  32'h5,        32'h7,        16'h0,    5'd0,  32'h0000000C, 1'b1, 1'b0, 8'd1},  // R1
        '{5'd2,  32'h0,        32'h1,        16'h0,    5'd0,  32'hFFFFFFFF, 1'b1, 1'b0, 8'd1},  // R1
        '{5'd3,  32'h10,       32'h3,        16'h0,    5'd0,  32'h0000000D, 1'b1, 1'b0, 8'd1},  // R1
        '{5'd0,  32'h7FFFFFFF, 32'h1,        16'h0,    5'd0,  32'h80000000, 1'b0, 1'b1, 8'd2},  // R2
        '{5'd2,  32'h80000000, 32'h1,        16'h0,    5'd0,  32'h7FFFFFFF, 1'b0, 1'b1, 8'd2},  // R2
        '{5'd10, 32'h7FFFFFF0, 32'h0,        16'h0010, 5'd0,  32'h80000000, 1'b0, 1'b1, 8'd2},  // R2
        '{5'd1,  32'h7FFFFFFF, 32'h1,        16'h0,    5'd0,  32'h80000000, 1'b1, 1'b0, 8'd3},  // R3
        '{5'd3,  32'h80000000, 32'h1,        16'h0,    5'd0,  32'h7FFFFFFF, 1'b1, 1'b0, 8'd3},  // R3
        '{5'd11, 32'h7FFFFFFF, 32'h0,        16'h0001, 5'd0,  32'h80000000, 1'b1, 1'b0, 8'd3},  // R3
        '{5'd11, 32'h10,       32'h0,        16'hFFFF, 5'd0,  32'h0000000F, 1'b1, 1'b0, 8'd4},  // R4
        '{5'd10, 32'h0,        32'h0,        16'h8000, 5'd0,  32'hFFFF8000, 1'b1, 1'b0, 8'd4},  // R4
        '{5'd4,  32'hF0F0F0F0, 32'hFF00FF00, 16'h0,    5'd0,  32'hF000F000, 1'b1, 1'b0, 8'd5},  // R5
        '{5'd5,  32'hF0F0F0F0, 32'hFF00FF00, 16'h0,    5'd0,  32'hFFF0FFF0, 1'b1, 1'b0, 8'd5},  // R5
        '{5'd6,  32'hF0F0F0F0, 32'hFF00FF00, 16'h0,    5'd0,  32'h0FF00FF0, 1'b1, 1'b0, 8'd5},  // R5
        '{5'd7,  32'hF0F0F0F0, 32'hFF00FF00, 16'h0,    5'd0,  32'h000F000F, 1'b1, 1'b0, 8'd5},  // R5
        '{5'd12, 32'hFFFFFFFF, 32'h0,        16'h8001, 5'd0,  32'h00008001, 1'b1, 1'b0, 8'd6},  // R6
        '{5'd13, 32'h0,        32'h0,        16'hFFFF, 5'd0,  32'h0000FFFF, 1'b1, 1'b0, 8'd6},  // R6
        '{5'd14, 32'hFFFFFFFF, 32'h0,        16'hF0F0, 5'd0,  32'hFFFF0F0F, 1'b1, 1'b0, 8'd6},  // R6
        '{5'd8,  32'hFFFFFFFF, 32'h1,        16'h0,    5'd0,  32'h1,        1'b1, 1'b0, 8'd7},  // R7
        '{5'd8,  32'h1,        32'hFFFFFFFF, 16'h0,    5'd0,  32'h0,        1'b1, 1'b0, 8'd7},  // R7
        '{5'd8,  32'h80000000, 32'h7FFFFFFF, 16'h0,    5'd0,  32'h1,        1'b1, 1'b0, 8'd7},  // R7
        '{5'd8,  32'h5,        32'h5,        16'h0,    5'd0,  32'h0,        1'b1, 1'b0, 8'd7},  // R7
        '{5'd15, 32'hFFFFFFFE, 32'h0,        16'hFFFF, 5'd0,  32'h1,        1'b1, 1'b0, 8'd7},  // R7
        '{5'd9,  32'hFFFFFFFF, 32'h1,        16'h0,    5'd0,  32'h0,        1'b1, 1'b0, 8'd8},  // R8
        '{5'd9,  32'h1,        32'hFFFFFFFF, 16'h0,    5'd0,  32'h1,        1'b1, 1'b0, 8'd8},  // R8
        '{5'd16, 32'hFFFFFFFE, 32'h0,        16'hFFFF, 5'd0,  32'h1,        1'b1, 1'b0, 8'd8},  // R8
        '{5'd16, 32'h00010000, 32'h0,        16'h8000, 5'd0,  32'h1,        1'b1, 1'b0, 8'd4},  // R4
        '{5'd17, 32'h12345678, 32'h9ABCDEF0, 16'hABCD, 5'd3,  32'hABCD0000, 1'b1, 1'b0, 8'd11}, // R11
        '{5'd18, 32'h0,        32'h00000001, 16'h0,    5'd31, 32'h80000000, 1'b1, 1'b0, 8'd9},  // R9
        '{5'd19, 32'h0,        32'h80000000, 16'h0,    5'd4,  32'h08000000, 1'b1, 1'b0, 8'd9},  // R9
        '{5'd20, 32'h0,        32'h80000000, 16'h0,    5'd4,  32'hF8000000, 1'b1, 1'b0, 8'd9},  // R9
        '{5'd20, 32'h0,        32'h40000000, 16'h0,    5'd4,  32'h04000000, 1'b1, 1'b0, 8'd9},  // R9
        '{5'd21, 32'hFFFFFFE3, 32'h00000001, 16'h0,    5'd7,  32'h00000008, 1'b1, 1'b0, 8'd10}, // R10
        '{5'd22, 32'h00000024, 32'hF0000000, 16'h0,    5'd0,  32'h0F000000, 1'b1, 1'b0, 8'd10}, // R10
        '{5'd23, 32'h0000003F, 32'hF0000000, 16'h0,    5'd1,  32'hFFFFFFFF, 1'b1, 1'b0, 8'd10}, // R10
        '{5'd31, 32'h7FFFFFFF, 32'h1,        16'hFFFF, 5'd1,  32'h0,        1'b0, 1'b0, 8'd12}  // R12
    };

    task automatic check(input int req, input string what, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL R%0d %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic apply(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic [15:0] imm, input logic [4:0] sh);
        @(negedge clk);
        op_i = op; a_i = a; b_i = b; imm_i = imm; shamt_i = sh;
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        // R13: overflowing operation held on the inputs during reset
        apply(5'd0, 32'h7FFFFFFF, 32'h1, 16'h0, 5'd0);
        @(posedge clk); #1;
        check(13, "ovf under reset", {31'b0, ovf_o}, 32'h0);
        @(posedge clk); #1;
        check(13, "ovf under reset again", {31'b0, ovf_o}, 32'h0);
        apply(5'd1, 32'h0, 32'h0, 16'h0, 5'd0);
        rst = 1'b0;
        @(posedge clk); #1;
        check(13, "ovf after reset", {31'b0, ovf_o}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].imm, VECS[i].sh);
            check(VECS[i].req, $sformatf("vec %0d result", i), result_o, VECS[i].res);
            check(VECS[i].req, $sformatf("vec %0d wr_en", i), {31'b0, wr_en_o}, {31'b0, VECS[i].wen});
            @(posedge clk); #1;
            check(VECS[i].req, $sformatf("vec %0d ovf", i), {31'b0, ovf_o}, {31'b0, VECS[i].ovf});
        end

        // R2: back-to-back overflows give one strobe per operation, then clear
        apply(5'd0, 32'h80000000, 32'h80000000, 16'h0, 5'd0);
        check(2, "b2b first result", result_o, 32'h0);
        @(posedge clk); #1;
        check(2, "b2b first ovf", {31'b0, ovf_o}, 32'h1);
        apply(5'd2, 32'h7FFFFFFF, 32'hFFFFFFFF, 16'h0, 5'd0);
        check(2, "b2b second wr_en", {31'b0, wr_en_o}, 32'h0);
        @(posedge clk); #1;
        check(2, "b2b second ovf", {31'b0, ovf_o}, 32'h1);
        apply(5'd0, 32'h1, 32'h1, 16'h0, 5'd0);
        @(posedge clk); #1;
        check(2, "ovf cleared", {31'b0, ovf_o}, 32'h0);

        // R10: upper count bits and the constant count have no effect
        apply(5'd22, 32'hFFFFFFE1, 32'h80000000, 16'h0, 5'd31);
        check(10, "shrv upper bits ignored", result_o, 32'h40000000);

        // R12: undefined code 24 with overflowing operands
        apply(5'd24, 32'h7FFFFFFF, 32'h1, 16'h1234, 5'd0);
        check(12, "undef result", result_o, 32'h0);
        check(12, "undef wr_en", {31'b0, wr_en_o}, 32'h0);
        @(posedge clk); #1;
        check(12, "undef ovf", {31'b0, ovf_o}, 32'h0);

        finish_run();
    end

    initial begin
        #(8 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end
endmodule